// File: doc/BRIEF.md
# Debug Test Access Port for a Stack CPU

This block lets an external debugger, working over the four-wire JTAG pins, hold a small stack-based soft CPU in emulation, feed it single instruction words and read back its registers. A 4-bit instruction register selects one of several data chains. One chain holds the instruction word presented to the CPU. One reads the 32-bit word at the top of the CPU stack. One is a two-bit control word. One reads back the program counter, the stack pointer and the CPU state bits. Any other code selects the usual one-bit bypass register.

The control word carries two bits. The first is the emulation request level. The second asks that each new instruction word be executed as soon as it is loaded. When the second bit is set, completing a load of the instruction chain flips a toggle in the TCK domain. The system clock domain turns that toggle into a single-cycle execute strobe, so one load runs exactly one instruction. CPU values travel the other way through synchronizers into the TCK domain. The debugger is expected to read them only while the CPU is halted.

Top module: `dbg_tap_port`

## Requirements
- R1: The controller follows the standard 16-state JTAG state machine on rising TCK. Five consecutive TCK edges with TMS high reach Test-Logic-Reset from any state, and trst_n low (sampled on TCK) forces it.
- R2: The instruction register is 4 bits and shifts LSB first. Capture-IR loads 4'b0001. Code 0x1 selects the instruction chain, 0x2 the data chain, 0x3 the control chain and 0x4 the status chain. Every other code selects a 1-bit bypass that captures 0, so TDI reappears on TDO one TCK later.
- R3: TDO changes only on falling TCK. During Shift-IR or Shift-DR it shows bit 0 of the selected shift register; in all other states it is 0. Every chain shifts LSB first.
- R4: The control chain is 2 bits wide: bit 0 is the emulation request and bit 1 is execute-on-load. Update-DR writes the control word, and Capture-DR returns its present value.
- R5: emu_req is a level that follows control bit 0 after two system-clock synchronizer stages, and it stays high for as long as that bit is set.
- R6: The instruction chain is INSN_W bits wide. Update-DR drives the shifted word onto emu_insn, which otherwise holds its value. Capture-DR returns the current word.
- R7: Update-DR on the instruction chain with control bit 1 set produces exactly one emu_exec pulse in the system clock domain. With bit 1 clear, it produces none.
- R8: The data chain is 32 bits wide and captures cpu_tos after two TCK synchronizer stages.
- R9: The status chain captures {cpu_state, cpu_sp, cpu_pc}, with cpu_pc in the least significant bits, after two TCK synchronizer stages.
- R10: Test-Logic-Reset selects bypass, clears the control word (so emu_req falls) and keeps emu_insn. It leaves the execute toggle untouched, so no execute pulse results from it.
- R11: emu_exec is never high on two consecutive system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | CPU system clock |
| sys_rst_n | input | 1 | Synchronous active-low reset, system domain |
| tck | input | 1 | JTAG test clock |
| trst_n | input | 1 | Active-low test reset, sampled on TCK |
| tms | input | 1 | JTAG mode select |
| tdi | input | 1 | JTAG serial data in |
| tdo | output | 1 | JTAG serial data out, updated on falling TCK |
| cpu_pc | input | PC_W | CPU program counter |
| cpu_sp | input | SP_W | CPU stack pointer |
| cpu_tos | input | DATA_W | Word at the CPU stack pointer |
| cpu_state | input | ST_W | CPU state bits |
| emu_req | output | 1 | Emulation request level, system domain |
| emu_exec | output | 1 | One-cycle execute strobe, system domain |
| emu_insn | output | INSN_W | Emulated instruction word |

## Verification
Some properties are checked on every cycle. These are the reach of five TMS-high edges into Test-Logic-Reset, the silence of TDO outside the shift states, and the holding of the instruction word between loads. The effect of Test-Logic-Reset on the selected chain and the control word is also checked every cycle, along with the flip or non-flip of the execute toggle on each load and the width of the execute strobe. The bench scenarios show the rest. They show the bit order and captured contents of every chain, the bypass delay, and the one-pulse-per-load count across the clock crossing. They also show the lag of the request level into the system domain, and that a reset through TMS leaves the instruction word and the pulse count alone.

// File: rtl/dbg_tap_pkg.sv
// Shared types for the debug test access port: controller states,
// instruction codes and the next-state function of the JTAG controller.
package dbg_tap_pkg;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    localparam int IR_W   = 4;
    localparam int CTRL_W = 2;

    localparam logic [IR_W-1:0] OP_EMUIR   = 4'h1;
    localparam logic [IR_W-1:0] OP_EMUDATA = 4'h2;
    localparam logic [IR_W-1:0] OP_CTRL    = 4'h3;
    localparam logic [IR_W-1:0] OP_STATUS  = 4'h4;
    localparam logic [IR_W-1:0] OP_BYPASS  = 4'hF;
    localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

    // Next controller state for a given TMS value.
    function automatic tap_state_e tap_next(tap_state_e s, logic tms);
        tap_state_e n;
        case (s)
            ST_RESET:  n = tms ? ST_RESET  : ST_IDLE;
            ST_IDLE:   n = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: n = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: n = tms ? ST_EX1_DR : ST_SHF_DR;
            ST_SHF_DR: n = tms ? ST_EX1_DR : ST_SHF_DR;
            ST_EX1_DR: n = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: n = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: n = tms ? ST_UPD_DR : ST_SHF_DR;
            ST_UPD_DR: n = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: n = tms ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: n = tms ? ST_EX1_IR : ST_SHF_IR;
            ST_SHF_IR: n = tms ? ST_EX1_IR : ST_SHF_IR;
            ST_EX1_IR: n = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: n = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: n = tms ? ST_UPD_IR : ST_SHF_IR;
            ST_UPD_IR: n = tms ? ST_SEL_DR : ST_IDLE;
            default:   n = ST_RESET;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/dbg_tap_sync.sv
// Multi-stage flop synchronizer for a W-bit bus.
// Assumes a multi-bit bus is quasi-static while sampled (CPU halted,
// or only one bit changing at a time).
module dbg_tap_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // First stage samples the foreign-domain input.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        // Each further stage re-registers the previous one.
        always_ff @(posedge clk) begin
            if (!rst_n) stg[g] <= '0;
            else        stg[g] <= stg[g-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dbg_tap_fsm.sv
// JTAG controller state register. Advances on rising TCK from TMS;
// trst_n is sampled on TCK and forces Test-Logic-Reset.
module dbg_tap_fsm
    import dbg_tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state
);
    // Hold the controller state.
    always_ff @(posedge tck) begin
        if (!trst_n) state <= ST_RESET;
        else         state <= tap_next(state, tms);
    end
endmodule

// File: rtl/dbg_tap_regs.sv
// Instruction register, data chains, control word, instruction word,
// execute toggle and TDO driver, all in the TCK domain.
// Assumes CPU readback values arrive already synchronized to TCK.
module dbg_tap_regs
    import dbg_tap_pkg::*;
#(
    parameter int INSN_W = 8,
    parameter int DATA_W = 32,
    parameter int STAT_W = 36
) (
    input  logic              tck,
    input  logic              trst_n,
    input  logic              tdi,
    input  tap_state_e        state,
    input  logic [DATA_W-1:0] tos_s,
    input  logic [STAT_W-1:0] stat_s,
    output logic              tdo,
    output logic [IR_W-1:0]   ir_q,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic              exec_tgl,
    output logic [INSN_W-1:0] emu_insn
);
    localparam int MAX1 = (DATA_W > STAT_W) ? DATA_W : STAT_W;
    localparam int MAX2 = (MAX1 > INSN_W) ? MAX1 : INSN_W;
    localparam int DR_W = (MAX2 > CTRL_W) ? MAX2 : CTRL_W;

    logic [IR_W-1:0] ir_sr;
    logic [DR_W-1:0] dr_sr;
    logic [DR_W-1:0] cap_val;
    int              chain_len;

    // Shift one bit into a chain of length len, LSB leaving first.
    function automatic logic [DR_W-1:0] shift_chain(logic [DR_W-1:0] sr, logic bit_in, int len);
        logic [DR_W-1:0] sh;
        logic [DR_W-1:0] r;
        sh = sr >> 1;
        for (int i = 0; i < DR_W; i++) begin
            if (i == len - 1)     r[i] = bit_in;
            else if (i < len - 1) r[i] = sh[i];
            else                  r[i] = 1'b0;
        end
        return r;
    endfunction

    // Length of the chain picked by the current instruction.
    always_comb begin
        case (ir_q)
            OP_EMUIR:   chain_len = INSN_W;
            OP_EMUDATA: chain_len = DATA_W;
            OP_CTRL:    chain_len = CTRL_W;
            OP_STATUS:  chain_len = STAT_W;
            default:    chain_len = 1;
        endcase
    end

    // Value loaded into the data shift register at Capture-DR.
    always_comb begin
        cap_val = '0;
        case (ir_q)
            OP_EMUIR:   cap_val[INSN_W-1:0] = emu_insn;
            OP_EMUDATA: cap_val[DATA_W-1:0] = tos_s;
            OP_CTRL:    cap_val[CTRL_W-1:0] = ctrl_q;
            OP_STATUS:  cap_val[STAT_W-1:0] = stat_s;
            default:    cap_val = '0;
        endcase
    end

    // Instruction register capture, shift and update.
    always_ff @(posedge tck) begin
        if (!trst_n) begin
            ir_sr <= '0;
            ir_q  <= OP_BYPASS;
        end else begin
            case (state)
                ST_RESET:  ir_q  <= OP_BYPASS;
                ST_CAP_IR: ir_sr <= IR_CAPTURE;
                ST_SHF_IR: ir_sr <= {tdi, ir_sr[IR_W-1:1]};
                ST_UPD_IR: ir_q  <= ir_sr;
                default:   ;
            endcase
        end
    end

    // Data shift register capture and shift.
    always_ff @(posedge tck) begin
        if (!trst_n)                dr_sr <= '0;
        else if (state == ST_CAP_DR) dr_sr <= cap_val;
        else if (state == ST_SHF_DR) dr_sr <= shift_chain(dr_sr, tdi, chain_len);
    end

    // Control word: written at Update-DR, cleared in Test-Logic-Reset.
    always_ff @(posedge tck) begin
        if (!trst_n || state == ST_RESET)
            ctrl_q <= '0;
        else if (state == ST_UPD_DR && ir_q == OP_CTRL)
            ctrl_q <= dr_sr[CTRL_W-1:0];
    end

    // Instruction word load and execute toggle on instruction-chain update.
    always_ff @(posedge tck) begin
        if (!trst_n) begin
            emu_insn <= '0;
            exec_tgl <= 1'b0;
        end else if (state == ST_UPD_DR && ir_q == OP_EMUIR) begin
            emu_insn <= dr_sr[INSN_W-1:0];
            if (ctrl_q[1]) exec_tgl <= ~exec_tgl;
        end
    end

    // TDO is launched on falling TCK from the active shift register.
    always_ff @(negedge tck) begin
        if (!trst_n)                 tdo <= 1'b0;
        else if (state == ST_SHF_IR) tdo <= ir_sr[0];
        else if (state == ST_SHF_DR) tdo <= dr_sr[0];
        else                         tdo <= 1'b0;
    end
endmodule

// File: rtl/dbg_tap_sysif.sv
// System-clock side: synchronizes the request level and the execute
// toggle, and turns each toggle edge into a one-cycle strobe.
// Assumes the toggle changes at most once per several system clocks.
module dbg_tap_sysif #(
    parameter int SYNC_STAGES = 2
) (
    input  logic sys_clk,
    input  logic sys_rst_n,
    input  logic req_lvl,
    input  logic exec_tgl,
    output logic emu_req,
    output logic emu_exec
);
    logic [1:0] synced;
    logic       tgl_prev;

    dbg_tap_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (sys_clk),
        .rst_n (sys_rst_n),
        .d     ({exec_tgl, req_lvl}),
        .q     (synced)
    );

    // Remember the last synchronized toggle value for edge detection.
    always_ff @(posedge sys_clk) begin
        if (!sys_rst_n) tgl_prev <= 1'b0;
        else            tgl_prev <= synced[1];
    end

    assign emu_req  = synced[0];
    assign emu_exec = synced[1] ^ tgl_prev;
endmodule

// File: rtl/dbg_tap_port.sv
// Debug test access port for a stack CPU. Joins the JTAG controller,
// the TCK-domain registers and both clock-domain crossings.
// Assumes trst_n is only asserted together with sys_rst_n.
module dbg_tap_port
    import dbg_tap_pkg::*;
#(
    parameter int INSN_W      = 8,
    parameter int DATA_W      = 32,
    parameter int PC_W        = 16,
    parameter int SP_W        = 16,
    parameter int ST_W        = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              sys_clk,
    input  logic              sys_rst_n,
    input  logic              tck,
    input  logic              trst_n,
    input  logic              tms,
    input  logic              tdi,
    output logic              tdo,
    input  logic [PC_W-1:0]   cpu_pc,
    input  logic [SP_W-1:0]   cpu_sp,
    input  logic [DATA_W-1:0] cpu_tos,
    input  logic [ST_W-1:0]   cpu_state,
    output logic              emu_req,
    output logic              emu_exec,
    output logic [INSN_W-1:0] emu_insn
);
    localparam int STAT_W = PC_W + SP_W + ST_W;

    tap_state_e        tap_state;
    logic [IR_W-1:0]   cur_ir;
    logic [CTRL_W-1:0] ctrl_bits;
    logic              exec_tgl;
    logic [DATA_W-1:0] tos_s;
    logic [STAT_W-1:0] stat_s;

    dbg_tap_fsm u_fsm (
        .tck    (tck),
        .trst_n (trst_n),
        .tms    (tms),
        .state  (tap_state)
    );

    dbg_tap_sync #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_tos_sync (
        .clk   (tck),
        .rst_n (trst_n),
        .d     (cpu_tos),
        .q     (tos_s)
    );

    dbg_tap_sync #(.W(STAT_W), .STAGES(SYNC_STAGES)) u_stat_sync (
        .clk   (tck),
        .rst_n (trst_n),
        .d     ({cpu_state, cpu_sp, cpu_pc}),
        .q     (stat_s)
    );

    dbg_tap_regs #(.INSN_W(INSN_W), .DATA_W(DATA_W), .STAT_W(STAT_W)) u_regs (
        .tck      (tck),
        .trst_n   (trst_n),
        .tdi      (tdi),
        .state    (tap_state),
        .tos_s    (tos_s),
        .stat_s   (stat_s),
        .tdo      (tdo),
        .ir_q     (cur_ir),
        .ctrl_q   (ctrl_bits),
        .exec_tgl (exec_tgl),
        .emu_insn (emu_insn)
    );

    dbg_tap_sysif #(.SYNC_STAGES(SYNC_STAGES)) u_sysif (
        .sys_clk   (sys_clk),
        .sys_rst_n (sys_rst_n),
        .req_lvl   (ctrl_bits[0]),
        .exec_tgl  (exec_tgl),
        .emu_req   (emu_req),
        .emu_exec  (emu_exec)
    );
endmodule

// File: rtl/dbg_tap_port_chk.sv
// Assertion checker for dbg_tap_port, attached by bind.
module dbg_tap_port_chk
    import dbg_tap_pkg::*;
#(
    parameter int INSN_W = 8
) (
    input logic              sys_clk,
    input logic              sys_rst_n,
    input logic              tck,
    input logic              trst_n,
    input logic              tms,
    input logic              tdo,
    input logic              emu_exec,
    input logic [INSN_W-1:0] emu_insn,
    input tap_state_e        state,
    input logic [IR_W-1:0]   ir,
    input logic [CTRL_W-1:0] ctrl,
    input logic              exec_tgl
);
    logic [2:0] tms_run;

    // Count consecutive TMS-high edges, saturating.
    always_ff @(posedge tck) begin
        if (!trst_n)  tms_run <= '0;
        else if (tms) tms_run <= (tms_run == 3'd7) ? 3'd7 : tms_run + 3'd1;
        else          tms_run <= '0;
    end

    // R1
    tms_reset_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (tms_run >= 3'd5) |-> (state == ST_RESET));

    // R3
    tdo_quiet_chk: assert property (@(posedge tck) disable iff (!trst_n)
        !(state == ST_SHF_IR || state == ST_SHF_DR) |-> (tdo == 1'b0));

    // R6
    insn_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
        !(state == ST_UPD_DR && ir == OP_EMUIR) |=> $stable(emu_insn));

    // R7
    exec_flip_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_UPD_DR && ir == OP_EMUIR && ctrl[1]) |=> (exec_tgl != $past(exec_tgl)));

    // R7
    exec_still_chk: assert property (@(posedge tck) disable iff (!trst_n)
        !(state == ST_UPD_DR && ir == OP_EMUIR && ctrl[1]) |=> $stable(exec_tgl));

    // R10
    tlr_clear_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_RESET) |=> (ir == OP_BYPASS && ctrl == '0));

    // R11
    exec_single_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        emu_exec |=> !emu_exec);
endmodule

bind dbg_tap_port dbg_tap_port_chk #(.INSN_W(INSN_W)) u_chk (
    .sys_clk   (sys_clk),
    .sys_rst_n (sys_rst_n),
    .tck       (tck),
    .trst_n    (trst_n),
    .tms       (tms),
    .tdo       (tdo),
    .emu_exec  (emu_exec),
    .emu_insn  (emu_insn),
    .state     (tap_state),
    .ir        (cur_ir),
    .ctrl      (ctrl_bits),
    .exec_tgl  (exec_tgl)
);

// File: tb/test_dbg_tap_port.sv
module test_dbg_tap_port;
    localparam int INSN_W = 8;
    localparam int DATA_W = 32;
    localparam int PC_W   = 16;
    localparam int SP_W   = 16;
    localparam int ST_W   = 4;
    localparam int STAT_W = PC_W + SP_W + ST_W;

    logic sys_clk = 1'b0;
    logic sys_rst_n = 1'b0;
    logic tck = 1'b0;
    logic trst_n = 1'b0;
    logic tms = 1'b1;
    logic tdi = 1'b0;
    logic tdo;
    logic [PC_W-1:0]   cpu_pc = '0;
    logic [SP_W-1:0]   cpu_sp = '0;
    logic [DATA_W-1:0] cpu_tos = '0;
    logic [ST_W-1:0]   cpu_state = '0;
    logic emu_req, emu_exec;
    logic [INSN_W-1:0] emu_insn;

    dbg_tap_port i_dbg_tap_port (
        .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .tck(tck), .trst_n(trst_n),
        .tms(tms), .tdi(tdi), .tdo(tdo), .cpu_pc(cpu_pc), .cpu_sp(cpu_sp),
        .cpu_tos(cpu_tos), .cpu_state(cpu_state), .emu_req(emu_req),
        .emu_exec(emu_exec), .emu_insn(emu_insn)
    );

    always #4 sys_clk = ~sys_clk;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done = 1'b0;
    int  exec_count = 0;
    bit  exec_prev = 1'b0;
    bit  model_req = 1'b0;
    bit  req_busy = 1'b0;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Per-clock reference comparison in the system domain.
    always @(negedge sys_clk) begin
        if (sys_rst_n && !done) begin
            check("R11 strobe width", 64'(emu_exec & exec_prev), 64'd0);
            if (emu_exec) exec_count++;
            exec_prev = emu_exec;
            if (!req_busy) check("R5 request level", 64'(emu_req), 64'(model_req));
        end
    end

    task automatic tck_cycle(input logic m, input logic d, output logic q);
        tms = m; tdi = d;
        #10 q = tdo;
        tck = 1'b1;
        #20 tck = 1'b0;
        #10;
    endtask

    task automatic scan_ir(input logic [3:0] code, output logic [3:0] cap);
        logic q;
        tck_cycle(1'b1, 1'b0, q);
        tck_cycle(1'b1, 1'b0, q);
        tck_cycle(1'b0, 1'b0, q);
        tck_cycle(1'b0, 1'b0, q);
        for (int i = 0; i < 4; i++) begin
            tck_cycle(i == 3, code[i], q);
            cap[i] = q;
        end
        tck_cycle(1'b1, 1'b0, q);
        tck_cycle(1'b0, 1'b0, q);
    endtask

    task automatic scan_dr(input int len, input logic [63:0] din, output logic [63:0] cap);
        logic q;
        cap = '0;
        tck_cycle(1'b1, 1'b0, q);
        tck_cycle(1'b0, 1'b0, q);
        tck_cycle(1'b0, 1'b0, q);
        for (int i = 0; i < len; i++) begin
            tck_cycle(i == len - 1, din[i], q);
            cap[i] = q;
        end
        tck_cycle(1'b1, 1'b0, q);
        tck_cycle(1'b0, 1'b0, q);
    endtask

    task automatic idle(input int n);
        logic q;
        for (int i = 0; i < n; i++) tck_cycle(1'b0, 1'b0, q);
    endtask

    task automatic write_ctrl(input logic [1:0] v);
        logic [3:0]  c4;
        logic [63:0] c;
        req_busy = 1'b1;
        scan_ir(4'h3, c4);
        scan_dr(2, 64'(v), c);
        #100;
        model_req = v[0];
        req_busy = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [3:0]  c4;
        logic [63:0] c;
        logic        q;
        int          base;

        // Reset both domains (R1: trst_n forces reset).
        for (int i = 0; i < 3; i++) tck_cycle(1'b1, 1'b0, q);
        sys_rst_n = 1'b1;
        trst_n = 1'b1;
        #20;
        check("R1 reset tdo", 64'(tdo), 64'd0);
        check("R1 reset emu_req", 64'(emu_req), 64'd0);
        check("R1 reset emu_exec", 64'(emu_exec), 64'd0);
        check("R1 reset emu_insn", 64'(emu_insn), 64'd0);
        idle(2);
        check("R3 idle tdo low", 64'(tdo), 64'd0);

        // R2: IR capture pattern and bypass on reset IR.
        scan_dr(8, 64'hA5, c);
        check("R2 bypass after reset", c & 64'hFF, 64'h4A);
        scan_ir(4'h9, c4);
        check("R2 IR capture", 64'(c4), 64'h1);
        scan_dr(8, 64'h3C, c);
        check("R2 bypass unknown code", c & 64'hFF, 64'h78);

        // R4: control write and readback.
        req_busy = 1'b1;
        scan_ir(4'h3, c4);
        scan_dr(2, 64'h1, c);
        check("R4 control first capture", c & 64'h3, 64'h0);
        scan_dr(2, 64'h1, c);
        check("R4 control readback", c & 64'h3, 64'h1);
        #100;
        model_req = 1'b1;
        req_busy = 1'b0;
        check("R5 emu_req raised", 64'(emu_req), 64'd1);

        // R6/R7: load without execute.
        base = exec_count;
        scan_ir(4'h1, c4);
        scan_dr(INSN_W, 64'h5A, c);
        #200;
        check("R6 insn loaded", 64'(emu_insn), 64'h5A);
        check("R7 no pulse without exec bit", 64'(exec_count - base), 64'd0);

        // R7: load with execute, twice.
        write_ctrl(2'b11);
        scan_ir(4'h1, c4);
        scan_dr(INSN_W, 64'h3C, c);
        check("R6 insn readback", c & 64'hFF, 64'h5A);
        #200;
        check("R7 one pulse", 64'(exec_count - base), 64'd1);
        check("R6 insn after exec load", 64'(emu_insn), 64'h3C);
        scan_dr(INSN_W, 64'h81, c);
        check("R6 insn readback 2", c & 64'hFF, 64'h3C);
        #200;
        check("R7 second pulse", 64'(exec_count - base), 64'd2);

        // R8: data chain.
        cpu_tos = 32'hDEADBEEF;
        idle(3);
        scan_ir(4'h2, c4);
        scan_dr(DATA_W, 64'h0, c);
        check("R8 tos capture", c & 64'hFFFF_FFFF, 64'hDEADBEEF);
        cpu_tos = 32'h1234_5678;
        idle(3);
        scan_dr(DATA_W, 64'h0, c);
        check("R8 tos capture 2", c & 64'hFFFF_FFFF, 64'h12345678);

        // R9: status chain.
        cpu_pc = 16'hBEEF; cpu_sp = 16'h1234; cpu_state = 4'hA;
        idle(3);
        scan_ir(4'h4, c4);
        scan_dr(STAT_W, 64'h0, c);
        check("R9 status capture", c & ((64'd1 << STAT_W) - 1), 64'hA_1234_BEEF);

        // R10/R1: five TMS highs from Idle.
        base = exec_count;
        req_busy = 1'b1;
        for (int i = 0; i < 5; i++) tck_cycle(1'b1, 1'b0, q);
        tck_cycle(1'b0, 1'b0, q);
        #100;
        model_req = 1'b0;
        req_busy = 1'b0;
        check("R10 emu_req cleared", 64'(emu_req), 64'd0);
        check("R10 insn kept", 64'(emu_insn), 64'h81);
        check("R10 no pulse on reset", 64'(exec_count - base), 64'd0);
        scan_dr(4, 64'hF, c);
        check("R10 bypass selected", c & 64'hF, 64'hE);
        scan_ir(4'h3, c4);
        scan_dr(2, 64'h0, c);
        check("R10 control cleared", c & 64'h3, 64'h0);
        check("R3 tdo low after scans", 64'(tdo), 64'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule